// File: doc/BRIEF.md
# MDIO Command-Word Management Master

This block drives the station-management pins of an Ethernet PHY. Software writes one 32-bit command word, and the block emits exactly one management frame on the MDC clock and the MDIO data line. The word's fields supply the frame's start code, opcode, port address, register or device address and 16-bit data without any translation. The same shifter therefore produces Clause 22 read and write frames as well as Clause 45 address, write and read frames. A Clause 45 register access is two commands in a row, and software issues them in turn, waiting for the busy flag to clear after each one.

MDC is divided down from the system clock by a half-period count given on an input. MDIO is only ever updated one system clock after MDC falls, so its value is stable at every rising edge of MDC. On a read frame the master stops driving the line during the turnaround. It then shifts in the 16 data bits that the PHY returns and places them in the low half of the command word once the frame ends.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset the command word reads as all zeros, MDC is low and the MDIO output enable is low.
- R2: A write to the command word while idle with bit 31 set starts a frame. Bit 31 reads 1 from the next cycle until the frame ends, then reads 0. The output enable is never high while bit 31 reads 0.
- R3: A frame is 64 MDC periods, sent most significant bit first: 32 ones, then bits 17:16, bits 19:18, bits 24:20, bits 29:25, the turnaround pattern 1 then 0, and then bits 15:0. On non-read frames the output enable is high for all 64 bits.
- R4: A frame whose bit 19 is 1 (code 10 or 11) is a read. The output enable is low for the two turnaround bits and the 16 data bits. The data bits are sampled at rising edges of MDC, first bit into bit 15, and they replace bits 15:0 of the command word when the frame ends. Bits 30:16 keep their values.
- R5: MDC has a period of twice the half-period input in system clocks. Inputs below 2 behave as 2. MDC stays low whenever no frame is running.
- R6: MDIO and its output enable never change in the same system-clock cycle as an MDC edge. Each update comes one system clock after MDC falls.
- R7: A command write while bit 31 reads 1 is ignored. The stored word and the frame in progress are both unchanged.
- R8: A command write with bit 31 clear stores the word but sends no frame. Busy stays 0 and MDC stays low.
- R9: A Clause 45 address frame (start 00, opcode 00) that carries the register address in bits 15:0 can be followed by a Clause 45 read (start 00, opcode 11). The read returns the PHY's data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mdc_half | input | DIV_W | MDC half period in system clocks (minimum 2 applied) |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word write data |
| cmd_rdata | output | 32 | Command word read-back: busy flag, fields, data or captured read data |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO level seen at the pad |
| mdio_o | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable (pad driver control) |

## Verification
The assertions assume three things about the environment. The half-period input stays constant while a frame is running. The reset is synchronous. The PHY model changes MDIO only after MDC falls. The stimulus keeps to these assumptions: each scenario sets the divider before it issues its command and leaves it alone until busy clears, and the PHY model drives read data one time step after each falling edge of MDC. The edge-margin and output-release properties depend on a frame position exported from the shifter, so they describe the shifter's own bit counting as well as the pins.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_FIRST   = 46;
    localparam int DATA_FIRST = 48;
    localparam int DATA_W     = 16;

    // Command word layout; field order is fixed by software
    typedef struct packed {
        logic              go;
        logic              spare;
        logic [4:0]        dev;
        logic [4:0]        port;
        logic [1:0]        op;
        logic [1:0]        st;
        logic [DATA_W-1:0] data;
    } mdio_cmd_t;

    typedef enum logic {
        ENG_IDLE  = 1'b0,
        ENG_SHIFT = 1'b1
    } eng_state_e;

    // Upper opcode bit marks a read in both clause formats
    function automatic logic cmd_is_read(mdio_cmd_t c);
        return c.op[1];
    endfunction

    function automatic logic [FRAME_BITS-1:0] cmd_to_frame(mdio_cmd_t c);
        return {32'hFFFF_FFFF, c.st, c.op, c.port, c.dev, 2'b10, c.data};
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
`timescale 1ns/1ps
module mdio_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_in,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(2);

    logic [DIV_W-1:0] half_eff;
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign half_eff = (half_in < MIN_HALF) ? MIN_HALF : half_in;
    assign wrap     = (cnt >= half_eff - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt      <= '0;
            mdc      <= 1'b0;
            rise_stb <= 1'b0;
            fall_stb <= 1'b0;
        end else begin
            rise_stb <= 1'b0;
            fall_stb <= 1'b0;
            if (wrap) begin
                cnt      <= '0;
                mdc      <= ~mdc;
                rise_stb <= ~mdc;
                fall_stb <= mdc;
            end else begin
                cnt <= cnt + DIV_W'(1);
            end
        end
    end

endmodule

// File: rtl/mdio_frame_eng.sv
`timescale 1ns/1ps
module mdio_frame_eng
    import mdio_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  mdio_cmd_t               cmd,
    input  logic                    rise_stb,
    input  logic                    fall_stb,
    input  logic                    mdio_i,
    output logic                    active,
    output logic                    done,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    mdio_o,
    output logic                    mdio_oe,
    output logic [IDX_W-1:0]        bit_pos
);
    localparam logic [IDX_W-1:0] LAST_POS  = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] TA_POS    = IDX_W'(TA_FIRST);
    localparam logic [IDX_W-1:0] DATA_POS  = IDX_W'(DATA_FIRST);

    eng_state_e              state;
    logic [FRAME_BITS-1:0]   shreg;
    logic [FRAME_BITS-1:0]   load_frame;
    logic                    rd_mode;
    logic [DATA_W-1:0]       cap;
    logic [IDX_W-1:0]        next_pos;

    assign load_frame = cmd_to_frame(cmd);
    assign next_pos   = bit_pos + IDX_W'(1);
    assign active     = (state == ENG_SHIFT);
    assign done       = active && fall_stb && (bit_pos == LAST_POS);
    assign rd_data    = cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ENG_IDLE;
            shreg   <= '0;
            rd_mode <= 1'b0;
            cap     <= '0;
            bit_pos <= '0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
        end else begin
            unique case (state)
                ENG_IDLE: begin
                    if (start) begin
                        state   <= ENG_SHIFT;
                        shreg   <= load_frame;
                        rd_mode <= cmd_is_read(cmd);
                        bit_pos <= '0;
                        mdio_o  <= load_frame[FRAME_BITS-1];
                        mdio_oe <= 1'b1;
                    end
                end
                ENG_SHIFT: begin
                    if (rise_stb && rd_mode && (bit_pos >= DATA_POS)) begin
                        cap <= {cap[DATA_W-2:0], mdio_i};
                    end
                    if (fall_stb) begin
                        if (bit_pos == LAST_POS) begin
                            state   <= ENG_IDLE;
                            mdio_o  <= 1'b1;
                            mdio_oe <= 1'b0;
                        end else begin
                            bit_pos <= next_pos;
                            shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
                            mdio_o  <= shreg[FRAME_BITS-2];
                            mdio_oe <= !(rd_mode && (next_pos >= TA_POS));
                        end
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mdio_cmd_master.sv
`timescale 1ns/1ps
module mdio_cmd_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] mdc_half,
    input  logic             cmd_we,
    input  logic [31:0]      cmd_wdata,
    output logic [31:0]      cmd_rdata,
    output logic             mdc,
    input  logic             mdio_i,
    output logic             mdio_o,
    output logic             mdio_oe
);
    mdio_cmd_t          cmd_q;
    mdio_cmd_t          cmd_in;
    logic               accept;
    logic               launch;
    logic               eng_active;
    logic               eng_done;
    logic               rise_stb;
    logic               fall_stb;
    logic [DATA_W-1:0]  eng_rdata;
    logic [IDX_W-1:0]   bit_pos;

    assign cmd_in    = mdio_cmd_t'(cmd_wdata);
    assign accept    = cmd_we && !cmd_q.go;
    assign launch    = accept && cmd_in.go;
    assign cmd_rdata = cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (accept) begin
            cmd_q <= cmd_in;
        end else if (eng_done) begin
            cmd_q.go <= 1'b0;
            if (cmd_is_read(cmd_q)) begin
                cmd_q.data <= eng_rdata;
            end
        end
    end

    mdio_clk_div #(.DIV_W(DIV_W)) div_i (
        .clk      (clk),
        .rst      (rst),
        .run      (eng_active),
        .half_in  (mdc_half),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_eng eng_i (
        .clk      (clk),
        .rst      (rst),
        .start    (launch),
        .cmd      (cmd_in),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .active   (eng_active),
        .done     (eng_done),
        .rd_data  (eng_rdata),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .bit_pos  (bit_pos)
    );

endmodule

// File: rtl/mdio_cmd_master_chk.sv
`timescale 1ns/1ps
module mdio_cmd_master_chk
    import mdio_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cmd_we,
    input logic [31:0]      cmd_wdata,
    input logic [31:0]      cmd_rdata,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic [IDX_W-1:0] bit_pos
);
    localparam logic [IDX_W-1:0] TA_POS = IDX_W'(TA_FIRST);

    assert_idle_no_drive_R2: assert property (@(posedge clk) disable iff (rst)
        !cmd_rdata[31] |-> !mdio_oe);

    assert_write_drives_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_rdata[31] && (bit_pos < TA_POS)) |-> mdio_oe);

    assert_read_release_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_rdata[31] && cmd_rdata[19] && (bit_pos >= TA_POS)) |-> !mdio_oe);

    assert_mdc_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !cmd_rdata[31] |-> !mdc);

    assert_rise_margin_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    assert_fall_margin_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    assert_hold_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_rdata[31] && $past(cmd_rdata[31])) |-> $stable(cmd_rdata[30:16]));

    assert_no_launch_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && !cmd_rdata[31] && !cmd_wdata[31]) |=> !cmd_rdata[31]);

endmodule

bind mdio_cmd_master mdio_cmd_master_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .cmd_we    (cmd_we),
    .cmd_wdata (cmd_wdata),
    .cmd_rdata (cmd_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .bit_pos   (bit_pos)
);

// File: tb/mdio_cmd_master_tb_top.sv
`timescale 1ns/1ps
module mdio_cmd_master_tb_top;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [DIV_W-1:0] mdc_half = DIV_W'(2);
    logic             cmd_we = 1'b0;
    logic [31:0]      cmd_wdata = '0;
    logic [31:0]      cmd_rdata;
    logic             mdc;
    logic             mdio_i = 1'b1;
    logic             mdio_o;
    logic             mdio_oe;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    // PHY model state
    logic [63:0] seen_bits = '0;
    logic [63:0] seen_oe = '0;
    int          rises = 0;
    logic [15:0] phy_rv = '0;
    time         last_rise = 0;
    time         period_meas = 0;
    logic        last_rise_val = 1'b1;
    int          margin_err = 0;

    always #5 clk = ~clk;

    mdio_cmd_master #(.DIV_W(DIV_W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .mdc_half  (mdc_half),
        .cmd_we    (cmd_we),
        .cmd_wdata (cmd_wdata),
        .cmd_rdata (cmd_rdata),
        .mdc       (mdc),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    always @(posedge mdc) begin
        seen_bits = {seen_bits[62:0], mdio_o};
        seen_oe   = {seen_oe[62:0], mdio_oe};
        if (rises == 1) period_meas = $time - last_rise;
        last_rise     = $time;
        last_rise_val = mdio_o;
        rises         = rises + 1;
    end

    always @(negedge mdc) begin
        #1;
        if (mdio_oe && (mdio_o !== last_rise_val)) margin_err = margin_err + 1;
        if (rises >= 48 && rises <= 63) mdio_i = phy_rv[63 - rises];
        else mdio_i = 1'b1;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_frame(input logic [31:0] c);
        return {32'hFFFF_FFFF, c[17:16], c[19:18], c[24:20], c[29:25], 2'b10, c[15:0]};
    endfunction

    task automatic write_cmd(input logic [31:0] w);
        @(negedge clk);
        cmd_we    = 1'b1;
        cmd_wdata = w;
        @(negedge clk);
        cmd_we    = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (cmd_rdata[31] && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(req, {63'd0, cmd_rdata[31]}, 64'd0);
    endtask

    task automatic launch(input logic [31:0] c, input int half, input logic [15:0] rv);
        mdc_half   = DIV_W'(half);
        phy_rv     = rv;
        rises      = 0;
        margin_err = 0;
        write_cmd(c);
        check("R2 busy after launch", {63'd0, cmd_rdata[31]}, 64'd1);
    endtask

    task automatic t_reset();
        check("R1 reset word", {32'd0, cmd_rdata}, 64'd0);
        check("R1 reset mdc/oe", {62'd0, mdc, mdio_oe}, 64'd0);
    endtask

    task automatic t_c22_write();
        logic [31:0] c = 32'h8000_0000 | (5'h0A << 25) | (5'h13 << 20) | (2'b01 << 18) | (2'b01 << 16) | 16'hA5C3;
        launch(c, 2, 16'h0000);
        wait_idle("R2 busy clears");
        check("R3 frame bits", seen_bits, exp_frame(c));
        check("R3 oe all bits", seen_oe, {64{1'b1}});
        check("R3 bit count", 64'(rises), 64'd64);
        check("R5 period half=2", 64'(period_meas), 64'd40);
        check("R6 edge margin", 64'(margin_err), 64'd0);
        check("R5 mdc low idle", {63'd0, mdc}, 64'd0);
        check("R2 oe low idle", {63'd0, mdio_oe}, 64'd0);
    endtask

    task automatic t_c22_read();
        logic [31:0] c = 32'h8000_0000 | (5'h01 << 25) | (5'h07 << 20) | (2'b10 << 18) | (2'b01 << 16);
        launch(c, 3, 16'h3C5A);
        wait_idle("R2 busy clears read");
        check("R4 header bits", {18'd0, seen_bits[63:18]}, {18'd0, exp_frame(c) >> 18});
        check("R4 oe released", seen_oe, {{46{1'b1}}, 18'd0});
        check("R4 read data", {48'd0, cmd_rdata[15:0]}, 64'h3C5A);
        check("R4 fields kept", {49'd0, cmd_rdata[30:16]}, {49'd0, c[30:16]});
        check("R5 period half=3", 64'(period_meas), 64'd60);
    endtask

    task automatic t_half_min();
        logic [31:0] c = 32'h8000_0000 | (5'h1F << 25) | (5'h00 << 20) | (2'b01 << 18) | (2'b00 << 16) | 16'h0F0F;
        launch(c, 0, 16'h0000);
        wait_idle("R2 busy clears min");
        check("R5 period half=0 acts as 2", 64'(period_meas), 64'd40);
        check("R3 c45 write bits", seen_bits, exp_frame(c));
        check("R6 edge margin min", 64'(margin_err), 64'd0);
    endtask

    task automatic t_c45_seq();
        logic [31:0] a = 32'h8000_0000 | (5'h01 << 25) | (5'h03 << 20) | (2'b00 << 18) | (2'b00 << 16) | 16'h1234;
        logic [31:0] r = 32'h8000_0000 | (5'h01 << 25) | (5'h03 << 20) | (2'b11 << 18) | (2'b00 << 16);
        launch(a, 4, 16'h0000);
        wait_idle("R9 addr done");
        check("R9 address frame", seen_bits, exp_frame(a));
        launch(r, 2, 16'hBEEF);
        wait_idle("R9 read done");
        check("R9 read header", {18'd0, seen_bits[63:18]}, {18'd0, exp_frame(r) >> 18});
        check("R9 read data", {48'd0, cmd_rdata[15:0]}, 64'hBEEF);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] c = 32'h8000_0000 | (5'h05 << 25) | (5'h09 << 20) | (2'b01 << 18) | (2'b01 << 16) | 16'h6E21;
        launch(c, 2, 16'h0000);
        repeat (50) @(negedge clk);
        write_cmd(32'hFFFF_FFFF);
        check("R7 word kept", {32'd0, cmd_rdata}, {32'd0, c});
        wait_idle("R7 busy clears");
        check("R7 frame undisturbed", seen_bits, exp_frame(c));
        check("R7 one frame", 64'(rises), 64'd64);
    endtask

    task automatic t_store_only();
        logic [31:0] c = 32'h4ABC_1234;
        rises = 0;
        write_cmd(c);
        check("R8 stored", {32'd0, cmd_rdata}, {32'd0, c});
        repeat (30) @(negedge clk);
        check("R8 no busy", {63'd0, cmd_rdata[31]}, 64'd0);
        check("R8 no mdc", {62'd0, mdc, mdio_oe}, 64'd0);
        check("R8 no edges", 64'(rises), 64'd0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_c22_write();
        t_c22_read();
        t_half_min();
        t_c45_seq();
        t_busy_ignore();
        t_store_only();
        finish_run();
    end

endmodule